// File: doc/BRIEF.md
# E1 Transmit All-Ones Insertion and Clock Fallback Controller

This block sits in front of an E1 line transmitter and decides what appears on the bipolar transmit rails and on which clock each bit is launched. It runs on a free-running local oscillator clock, `osc_clk`. It treats the transmit clock and the master clock as inputs that it samples. Each of those two clocks is watched for activity. The bit rate comes from the highest-priority clock that is present: the transmit clock first, then the master clock, and if neither is present, a fixed division of the oscillator.

On every bit boundary the rails take one of three values. In all-ones mode they carry alternating marks. In normal operation they carry the incoming positive and negative data. When the high-impedance control is set, they are held quiet with the output enable dropped. A remote-loopback request suppresses any all-ones request. Whenever the effective all-ones state or the local-loopback control changes, a settling flag is raised for a fixed number of bit periods so that downstream logic can disregard the line while it stabilizes. The analog pulse shaper, the line drivers and the loopback data paths are outside this block.

Top module: `line_ones_ctrl`

## Requirements
- R1: When all-ones is requested and remote loopback is not, each bit carries exactly one mark, alternating between rails. The first mark after entry is on `line_pos`, and `tx_pos_in`/`tx_neg_in` have no effect on the rails.
- R2: While `rloop_req` is 1, `ones_req` has no effect: the rails carry the data inputs exactly as in R3.
- R3: With all-ones and high-impedance both inactive, each bit boundary copies `tx_pos_in`/`tx_neg_in`, as sampled on that boundary, onto `line_pos`/`line_neg`. The rails then hold those values until the next boundary.
- R4: While `hiz_req` is 1, from the next `osc_clk` edge `line_oe` is 0 and both rails are 0. This overrides R1 to R3. Otherwise `line_oe` is 1.
- R5: `sel_src` reports the bit-clock source: 0 for the transmit clock, 1 for the master clock, 2 for the oscillator. The source is the highest-priority present clock, in that order. Bits are spaced one period of the chosen clock apart, or `OSC_DIV` oscillator cycles apart for the oscillator.
- R6: A monitored clock is declared absent when no rising edge of it is seen for `MISS_LIMIT` (8) oscillator cycles. It is declared present again after `PRESENT_EDGES` (4) consecutive rising edges, each arriving inside that window.
- R7: `sel_src` changes only at a bit boundary. That boundary is a boundary of the old source, or, if the old source has been lost, the first boundary of the new source. Every change of `sel_src` is accompanied by `bit_strobe`.
- R8: When the effective all-ones state (`ones_req` and not `rloop_req`) or `lloop_req` changes, `settle` goes to 1 and stays at 1 until `SETTLE_BITS` (22) further bit boundaries have passed. A further change restarts the count.
- R9: During and immediately after reset, `sel_src` is 2, both rails are 0, and `settle` is 0. `line_oe` is 0 while reset is held.
- R10: `bit_strobe` is a one-cycle pulse in the cycle in which the rails first show a new bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Local oscillator clock; all logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_clk_in | input | 1 | Transmit clock, sampled and monitored |
| mst_clk_in | input | 1 | Master clock, sampled and monitored |
| tx_pos_in | input | 1 | Positive-rail transmit data |
| tx_neg_in | input | 1 | Negative-rail transmit data |
| ones_req | input | 1 | All-ones request |
| rloop_req | input | 1 | Remote loopback in effect |
| lloop_req | input | 1 | Local loopback control |
| hiz_req | input | 1 | High-impedance control, 1 = outputs off |
| line_pos | output | 1 | Positive rail to the line driver |
| line_neg | output | 1 | Negative rail to the line driver |
| line_oe | output | 1 | Driver enable, 0 = high impedance |
| bit_strobe | output | 1 | Pulse when a new bit appears on the rails |
| settle | output | 1 | Outputs still stabilizing after a control change |
| sel_src | output | 2 | Current bit-clock source (0 transmit, 1 master, 2 oscillator) |

## Verification
The situation that is hardest to reach from the ports is a change of clock source. It needs a clock to fall silent long enough to be declared lost, and it then needs a clean return that must not be accepted before enough edges have arrived. The bench starts and stops the two monitored clocks in sequence: first transmit, then master, then transmit again. After each step it measures, in oscillator cycles, how long `sel_src` takes to move, and checks that every move lands on a `bit_strobe`. Between these steps, random per-bit stimulus mixes all-ones, remote loopback, local-loopback toggles and high impedance. A bench model predicts the rails, the mark polarity, the spacing between bits and the settling count.

// File: rtl/line_ones_pkg.sv
// Shared types for the all-ones insertion controller.
// Assumes: the source code values are visible on the sel_src port.
package line_ones_pkg;

    // Bit-clock source, listed in falling priority
    typedef enum logic [1:0] {
        SRC_TX  = 2'd0,
        SRC_MST = 2'd1,
        SRC_OSC = 2'd2
    } src_e;

endpackage

// File: rtl/clk_presence_mon.sv
// Clock presence monitor.
// Samples an external clock on the oscillator clock, emits a one-cycle
// pulse per rising edge, and tracks whether the clock is alive.
// Assumes: the monitored clock is slower than half the oscillator rate.
module clk_presence_mon #(
    parameter int MISS_LIMIT    = 8,
    parameter int PRESENT_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    output logic rise,
    output logic present
);
    localparam int GW = $clog2(MISS_LIMIT + 1);
    localparam int EW = $clog2(PRESENT_EDGES + 1);
    localparam logic [GW-1:0] GAP_MAX  = GW'(MISS_LIMIT);
    localparam logic [GW-1:0] GAP_LAST = GW'(MISS_LIMIT - 1);
    localparam logic [EW-1:0] EDGE_LAST = EW'(PRESENT_EDGES - 1);

    logic [2:0]    samp_q;
    logic [GW-1:0] gap_q;
    logic [EW-1:0] edges_q;

    // Two-stage synchronizer plus a history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) samp_q <= '0;
        else        samp_q <= {samp_q[1:0], ext_clk};
    end

    assign rise = samp_q[1] & ~samp_q[2];

    // Counts oscillator cycles since the last seen edge, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)               gap_q <= '0;
        else if (rise)            gap_q <= '0;
        else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
    end

    // Declares loss on a full silent window, recovery after enough edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present <= 1'b0;
            edges_q <= '0;
        end else if (!rise && gap_q == GAP_LAST) begin
            present <= 1'b0;
            edges_q <= '0;
        end else if (rise && !present) begin
            if (edges_q == EDGE_LAST) begin
                present <= 1'b1;
                edges_q <= '0;
            end else begin
                edges_q <= edges_q + 1'b1;
            end
        end
    end

    // R6: a full silent window means the clock is not present
    a_r6_absent_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == GAP_MAX) |-> !present);

    // R6: recovery is only ever triggered by an observed edge
    a_r6_present_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(present) |-> $past(rise));

endmodule

// File: rtl/tx_clk_select.sv
// Bit-clock source selector.
// Picks the highest-priority present clock, produces the bit boundary
// tick, and changes source only at a boundary.
// Assumes: rise inputs are single-cycle pulses from the presence monitors.
module tx_clk_select
    import line_ones_pkg::*;
#(
    parameter int OSC_DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_rise,
    input  logic tx_present,
    input  logic mst_rise,
    input  logic mst_present,
    output src_e cur_src,
    output logic bit_tick
);
    localparam int DW = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(OSC_DIV - 1);

    logic [DW-1:0] div_q;
    logic          osc_tick;
    src_e          req_src;
    logic          cur_tick;
    logic          cur_ok;
    logic          req_tick;
    logic          switch_en;

    // Free-running oscillator divider for the fallback bit rate
    always_ff @(posedge clk) begin
        if (!rst_n)                div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else                       div_q <= div_q + 1'b1;
    end

    assign osc_tick = (div_q == DIV_LAST);

    // Priority choice among present sources
    always_comb begin
        if (tx_present)       req_src = SRC_TX;
        else if (mst_present) req_src = SRC_MST;
        else                  req_src = SRC_OSC;
    end

    // Tick and health of the source in use
    always_comb begin
        case (cur_src)
            SRC_TX:  begin cur_tick = tx_rise;  cur_ok = tx_present;  end
            SRC_MST: begin cur_tick = mst_rise; cur_ok = mst_present; end
            default: begin cur_tick = osc_tick; cur_ok = 1'b1;        end
        endcase
    end

    // Tick of the source that should be in use
    always_comb begin
        case (req_src)
            SRC_TX:  req_tick = tx_rise;
            SRC_MST: req_tick = mst_rise;
            default: req_tick = osc_tick;
        endcase
    end

    assign switch_en = (req_src != cur_src) && (cur_tick || (!cur_ok && req_tick));
    assign bit_tick  = cur_tick || switch_en;

    // Source register, moved only at a boundary
    always_ff @(posedge clk) begin
        if (!rst_n)         cur_src <= SRC_OSC;
        else if (switch_en) cur_src <= req_src;
    end

    // R7: the source changes only on a boundary of the old one or, if lost, of the new one
    a_r7_switch_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_src != $past(cur_src)) |-> $past(cur_tick || (!cur_ok && req_tick)));

    // R5: with both monitored clocks gone, the next boundary lands on the oscillator
    a_r5_fallback_osc: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_present && !mst_present && bit_tick) |=> (cur_src == SRC_OSC));

endmodule

// File: rtl/tx_line_path.sv
// Line data path.
// On each bit boundary loads either an alternating mark or the incoming
// rail data; forces quiet rails and a low enable in high impedance.
// Assumes: data inputs are already in the oscillator clock domain.
module tx_line_path (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic ones_eff,
    input  logic hiz,
    input  logic in_pos,
    input  logic in_neg,
    output logic line_pos,
    output logic line_neg,
    output logic line_oe,
    output logic strobe
);
    logic phase_q;

    // Output enable and boundary strobe follow one cycle behind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_oe <= 1'b0;
            strobe  <= 1'b0;
        end else begin
            line_oe <= ~hiz;
            strobe  <= bit_tick;
        end
    end

    // Mark polarity: cleared outside all-ones, flipped per mark sent
    always_ff @(posedge clk) begin
        if (!rst_n)                  phase_q <= 1'b0;
        else if (!ones_eff)          phase_q <= 1'b0;
        else if (bit_tick && !hiz)   phase_q <= ~phase_q;
    end

    // Rail registers, loaded at the bit boundary
    always_ff @(posedge clk) begin
        if (!rst_n || hiz) begin
            line_pos <= 1'b0;
            line_neg <= 1'b0;
        end else if (bit_tick) begin
            if (ones_eff) begin
                line_pos <= ~phase_q;
                line_neg <= phase_q;
            end else begin
                line_pos <= in_pos;
                line_neg <= in_neg;
            end
        end
    end

    // R1: an all-ones bit carries exactly one mark
    a_r1_single_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && ones_eff && !hiz) |=> (line_pos ^ line_neg));

    // R3: outside all-ones the rails take the sampled inputs
    a_r3_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !ones_eff && !hiz) |=>
        (line_pos == $past(in_pos) && line_neg == $past(in_neg)));

    // R4: high impedance quiets everything on the next edge
    a_r4_hiz_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        hiz |=> (!line_oe && !line_pos && !line_neg));

    // R10: each boundary is announced in the following cycle
    a_r10_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> strobe);

endmodule

// File: rtl/settle_timer.sv
// Settling window timer.
// Watches the effective all-ones state and the local-loopback control;
// after any change holds a flag for a fixed number of bit boundaries.
// Assumes: bit_tick marks bit boundaries of the selected source.
module settle_timer #(
    parameter int SETTLE_BITS = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic ones_eff,
    input  logic lloop,
    output logic settle
);
    localparam int CW = $clog2(SETTLE_BITS + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE_BITS);

    logic          ones_prev_q;
    logic          ll_prev_q;
    logic [CW-1:0] cnt_q;
    logic          toggle;

    // Remembers the controls to spot a change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_prev_q <= 1'b0;
            ll_prev_q   <= 1'b0;
        end else begin
            ones_prev_q <= ones_eff;
            ll_prev_q   <= lloop;
        end
    end

    assign toggle = (ones_eff ^ ones_prev_q) | (lloop ^ ll_prev_q);

    // Reloads on a change, counts down on boundaries
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (toggle)                  cnt_q <= CNT_LOAD;
        else if (bit_tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign settle = (cnt_q != '0);

    // R8: a control change always opens the window
    a_r8_toggle_opens: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> settle);

    // R8: the window never opens without a change
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!toggle && !settle) |=> !settle);

endmodule

// File: rtl/line_ones_ctrl.sv
// Top level of the transmit all-ones insertion controller.
// Monitors the transmit and master clocks, chooses the bit clock,
// drives the line rails and raises the settling flag.
// Assumes: osc_clk is always running and is the only clock of the block.
module line_ones_ctrl
    import line_ones_pkg::*;
#(
    parameter int MISS_LIMIT    = 8,
    parameter int PRESENT_EDGES = 4,
    parameter int OSC_DIV       = 5,
    parameter int SETTLE_BITS   = 22
) (
    input  logic       osc_clk,
    input  logic       rst_n,
    input  logic       tx_clk_in,
    input  logic       mst_clk_in,
    input  logic       tx_pos_in,
    input  logic       tx_neg_in,
    input  logic       ones_req,
    input  logic       rloop_req,
    input  logic       lloop_req,
    input  logic       hiz_req,
    output logic       line_pos,
    output logic       line_neg,
    output logic       line_oe,
    output logic       bit_strobe,
    output logic       settle,
    output logic [1:0] sel_src
);
    localparam int NMON = 2;

    logic [NMON-1:0] mon_in;
    logic [NMON-1:0] mon_rise;
    logic [NMON-1:0] mon_present;
    logic            ones_eff;
    logic            bit_tick;
    src_e            cur_src;

    assign mon_in   = {mst_clk_in, tx_clk_in};
    assign ones_eff = ones_req & ~rloop_req;

    // One presence monitor per external clock
    for (genvar g = 0; g < NMON; g++) begin : g_mon
        clk_presence_mon #(
            .MISS_LIMIT   (MISS_LIMIT),
            .PRESENT_EDGES(PRESENT_EDGES)
        ) mon_i (
            .clk    (osc_clk),
            .rst_n  (rst_n),
            .ext_clk(mon_in[g]),
            .rise   (mon_rise[g]),
            .present(mon_present[g])
        );
    end

    tx_clk_select #(
        .OSC_DIV(OSC_DIV)
    ) sel_i (
        .clk        (osc_clk),
        .rst_n      (rst_n),
        .tx_rise    (mon_rise[0]),
        .tx_present (mon_present[0]),
        .mst_rise   (mon_rise[1]),
        .mst_present(mon_present[1]),
        .cur_src    (cur_src),
        .bit_tick   (bit_tick)
    );

    tx_line_path path_i (
        .clk     (osc_clk),
        .rst_n   (rst_n),
        .bit_tick(bit_tick),
        .ones_eff(ones_eff),
        .hiz     (hiz_req),
        .in_pos  (tx_pos_in),
        .in_neg  (tx_neg_in),
        .line_pos(line_pos),
        .line_neg(line_neg),
        .line_oe (line_oe),
        .strobe  (bit_strobe)
    );

    settle_timer #(
        .SETTLE_BITS(SETTLE_BITS)
    ) settle_i (
        .clk     (osc_clk),
        .rst_n   (rst_n),
        .bit_tick(bit_tick),
        .ones_eff(ones_eff),
        .lloop   (lloop_req),
        .settle  (settle)
    );

    assign sel_src = cur_src;

    // R2: remote loopback leaves the rails on data even with all-ones asked
    a_r2_rloop_blocks: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (bit_tick && rloop_req && !hiz_req) |=>
        (line_pos == $past(tx_pos_in) && line_neg == $past(tx_neg_in)));

    // R7: a source change is always announced as a new bit
    a_r7_change_strobed: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (sel_src != $past(sel_src)) |-> bit_strobe);

endmodule

// File: tb/line_ones_ctrl_tb_top.sv
// Bench for line_ones_ctrl: random per-bit stimulus plus directed
// clock loss and recovery, checked against a bench-side model.
module line_ones_ctrl_tb_top;
    localparam int SETTLE_N = 22;
    localparam int OSC_DIV  = 5;

    logic osc_clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_clk = 1'b0, mst_clk = 1'b0;
    logic tx_run = 1'b0, mst_run = 1'b0;
    logic tx_pos = 1'b0, tx_neg = 1'b0;
    logic ones = 1'b0, rloop = 1'b0, lloop = 1'b0, hiz = 1'b0;
    logic line_pos, line_neg, line_oe, bit_strobe, settle;
    logic [1:0] sel_src;

    int checks = 0, fails = 0;
    int unsigned cyc = 0;
    int settle_cnt = 0;
    bit phase = 1'b0;
    int last_strobe = -1;
    bit done = 1'b0;

    line_ones_ctrl dut_i (
        .osc_clk(osc_clk), .rst_n(rst_n), .tx_clk_in(tx_clk), .mst_clk_in(mst_clk),
        .tx_pos_in(tx_pos), .tx_neg_in(tx_neg), .ones_req(ones), .rloop_req(rloop),
        .lloop_req(lloop), .hiz_req(hiz), .line_pos(line_pos), .line_neg(line_neg),
        .line_oe(line_oe), .bit_strobe(bit_strobe), .settle(settle), .sel_src(sel_src)
    );

    always #2 osc_clk = ~osc_clk;
    always begin #8;  if (tx_run)  tx_clk  = ~tx_clk;  end
    always begin #12; if (mst_run) mst_clk = ~mst_clk; end
    always @(posedge osc_clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Applies new controls and data, updating the model's settle and phase
    task automatic set_ctrl(input bit n_ones, input bit n_rl, input bit n_ll,
                            input bit n_hiz, input bit p, input bit n);
        bit old_eff = ones & ~rloop;
        bit new_eff = n_ones & ~n_rl;
        if ((old_eff != new_eff) || (lloop != n_ll)) settle_cnt = SETTLE_N;
        if (!new_eff) phase = 1'b0;
        ones = n_ones; rloop = n_rl; lloop = n_ll; hiz = n_hiz;
        tx_pos = p; tx_neg = n;
    endtask

    // Waits for the next strobe at a negative edge; watchdog per bit
    task automatic wait_strobe(output bit got);
        got = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge osc_clk);
            if (bit_strobe) begin got = 1'b1; break; end
        end
        if (!got) check(1'b0, "R10 strobe timeout", 0, 1);
    endtask

    // Checks one bit against the model
    task automatic check_bit(input int spacing);
        bit ep, en, eo;
        if (settle_cnt > 0) settle_cnt--;
        check(settle == (settle_cnt != 0), "R8 settle", settle, settle_cnt != 0);
        eo = ~hiz;
        if (hiz) begin ep = 0; en = 0; end
        else if (ones && !rloop) begin ep = ~phase; en = phase; phase = ~phase; end
        else begin ep = tx_pos; en = tx_neg; end
        if (hiz)                 check({line_oe, line_pos, line_neg} == {eo, ep, en}, "R4 hiz", {line_oe, line_pos, line_neg}, {eo, ep, en});
        else if (ones && !rloop) check({line_oe, line_pos, line_neg} == {eo, ep, en}, "R1 ones", {line_oe, line_pos, line_neg}, {eo, ep, en});
        else if (ones && rloop)  check({line_oe, line_pos, line_neg} == {eo, ep, en}, "R2 rloop", {line_oe, line_pos, line_neg}, {eo, ep, en});
        else                     check({line_oe, line_pos, line_neg} == {eo, ep, en}, "R3 data", {line_oe, line_pos, line_neg}, {eo, ep, en});
        if (spacing > 0 && last_strobe >= 0)
            check(int'(cyc) - last_strobe == spacing, "R5 spacing", int'(cyc) - last_strobe, spacing);
        last_strobe = int'(cyc);
        @(negedge osc_clk);
        check(bit_strobe == 1'b0, "R10 strobe width", bit_strobe, 0);
    endtask

    task automatic run_bits(input int n, input int spacing);
        bit got;
        for (int i = 0; i < n; i++) begin
            wait_strobe(got);
            if (!got) return;
            check_bit(spacing);
            set_ctrl(($urandom % 10) < 3, ($urandom % 10) < 2,
                     (($urandom % 10) == 0) ? ~lloop : lloop,
                     ($urandom % 10) == 0, $urandom % 2, $urandom % 2);
        end
    endtask

    // Measures cycles until sel_src reaches target; checks R7 on every change
    task automatic measure_sel(input logic [1:0] target, input int lo, input int hi, input string req);
        int n = 0;
        logic [1:0] prev = sel_src;
        set_ctrl(0, 0, lloop, 0, 1, 0);
        while (sel_src != target && n < 400) begin
            @(negedge osc_clk);
            n++;
            if (bit_strobe && settle_cnt > 0) settle_cnt--;
            if (sel_src != prev) check(bit_strobe == 1'b1, "R7 change on boundary", bit_strobe, 1);
            prev = sel_src;
        end
        check(n >= lo && n <= hi, req, n, lo);
        check(sel_src == target, "R5 source", sel_src, target);
        last_strobe = -1;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge osc_clk);
        check({line_pos, line_neg, line_oe, settle} == 4'b0, "R9 reset outputs",
              {line_pos, line_neg, line_oe, settle}, 0);
        check(sel_src == 2'd2, "R9 reset source", sel_src, 2);
        rst_n = 1'b1;
        @(negedge osc_clk);
        check(sel_src == 2'd2 && settle == 1'b0, "R9 after reset", {sel_src, settle}, 4);
        // oscillator bit rate before any clock runs
        run_bits(3, 0);
        run_bits(10, OSC_DIV);
        check(sel_src == 2'd2, "R5 osc only", sel_src, 2);
        // both clocks start: transmit clock wins
        tx_run = 1'b1; mst_run = 1'b1;
        measure_sel(2'd0, 12, 60, "R6 tx recovery time");
        run_bits(40, 0);
        run_bits(200, 4);
        // directed all-ones entry: first mark on positive rail
        set_ctrl(1, 0, lloop, 0, 0, 1);
        run_bits(30, 4);
        set_ctrl(1, 1, lloop, 0, 1, 1);
        run_bits(30, 4);
        // transmit clock lost: master takes over
        tx_run = 1'b0;
        measure_sel(2'd1, 6, 35, "R6 tx loss time");
        run_bits(3, 0);
        run_bits(150, 6);
        // master lost too: oscillator
        mst_run = 1'b0;
        measure_sel(2'd2, 6, 35, "R6 mst loss time");
        run_bits(3, 0);
        run_bits(120, OSC_DIV);
        // transmit clock returns
        tx_run = 1'b1;
        measure_sel(2'd0, 12, 60, "R6 tx return time");
        run_bits(3, 0);
        run_bits(150, 4);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule